// File: doc/BRIEF.md
# Serial Bus Mode Selector with SPI Lock

This block sits between a sensor's shared serial pads and its two protocol engines. It looks at the sampled chip-select and serial-clock levels and decides which engine owns the pads. Chip-select high gives the pads to the I2C slave engine. Chip-select low gives them to the SPI slave engine. A small counter watches the serial clock while chip-select is low. Once it has seen a fixed number of rising clock edges, the block locks into SPI mode. It stays there, whatever chip-select does, until the power-on reset is applied. The lock keeps SPI traffic addressed to another slave on the same wires from ever being decoded as I2C.

The block also steers the pad output enables for the two SPI variants. A configuration bit picks between them. With the bit at 0 (4-wire SPI, the reset default), read data leaves on the dedicated serial-data-out pad. With the bit at 1 (3-wire SPI), read data is driven back onto the data-input pad. The SPI engine only asks to drive. This block grants the request while chip-select is low and tri-states both pads otherwise.

The pad levels pass through a synchronizer of `SYNC_STAGES` flops. All outputs are registered.

Top module: `serbus_mode_sel`

## Requirements
- R1: With no lock and chip-select high (`chip_sel_n` = 1), `i2c_en` is 1 and `spi_en` is 0. The two enables are never both 1.
- R2: With chip-select low (`chip_sel_n` = 0), `spi_en` is 1 and `i2c_en` is 0.
- R3: Chip-select is held low. After the fourth rising edge of `sck_pin`, `spi_locked` becomes 1. After three edges it stays 0. The edge counter never exceeds four.
- R4: Once `spi_locked` is 1, it stays 1. With chip-select high, `i2c_en` stays 0 and `spi_en` stays 1. Only a low `rst_n` clears this state.
- R5: A return of chip-select to high before the lock is reached clears the edge count. A rising clock edge that is sampled in the same cycle as chip-select going high is not counted.
- R6: A one-cycle `soft_rst` pulse clears the edge count. It leaves `spi_locked` unchanged.
- R7: With `cfg_wire` = 0 (4-wire) and chip-select low, `sdo_oe` follows `rd_drive` and `sdi_oe` stays 0.
- R8: With `cfg_wire` = 1 (3-wire) and chip-select low, `sdi_oe` follows `rd_drive` and `sdo_oe` stays 0. The two output enables are never both 1.
- R9: With chip-select high, `sdo_oe` and `sdi_oe` are 0 whatever `rd_drive` is.
- R10: After reset, `spi_locked`, `sdo_oe` and `sdi_oe` are 0. With chip-select high, the block settles in I2C mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low; the only clear for the lock |
| soft_rst | input | 1 | One-cycle pulse from the register-file soft reset; clears the edge count only |
| chip_sel_n | input | 1 | Sampled chip-select pad level, 1 = deselected / I2C |
| sck_pin | input | 1 | Sampled serial-clock pad level |
| cfg_wire | input | 1 | SPI variant: 0 = 4-wire, 1 = 3-wire |
| rd_drive | input | 1 | SPI engine wants to drive read data |
| i2c_en | output | 1 | Enable for the I2C slave engine |
| spi_en | output | 1 | Enable for the SPI slave engine, also the bus-mode indication |
| spi_locked | output | 1 | Sticky SPI lock state |
| sdi_oe | output | 1 | Output enable of the data-input pad (3-wire read) |
| sdo_oe | output | 1 | Output enable of the data-output pad (4-wire read) |

## Verification
Two events can land in the same sampled cycle: the rising clock edge that would complete the lock, and chip-select returning high. The bench provokes this by driving both pads in one step after three counted edges. Both pads pass through synchronizers of equal depth, so the two changes reach the counter in the same cycle. The bench then expects `spi_locked` to stay 0 and the block to return to I2C mode, because an edge seen while deselected must not count.

// File: rtl/serbus_pkg.sv
// Package: shared types and constants for the serial bus mode selector.
// Assumes: imported by every module of the block.
package serbus_pkg;

    // Bus owner of the shared pads
    typedef enum logic {
        BUS_I2C = 1'b0,
        BUS_SPI = 1'b1
    } bus_mode_e;

    // SPI variant chosen by the wire-mode configuration bit
    typedef enum logic {
        SPI_4WIRE = 1'b0,
        SPI_3WIRE = 1'b1
    } spi_wire_e;

endpackage

// File: rtl/serbus_pin_sync.sv
// Module: serbus_pin_sync
// What it does: it passes a group of asynchronous pad levels through a chain
//               of STAGES flops, one chain per bit.
// Assumes: STAGES >= 1. RST_VAL is the idle level of each pad, so that
//          no edge appears at reset release.
module serbus_pin_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] pin_s
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: capture the raw pad level
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= pin_i;
                end
            end else begin : g_next
                // Purpose: settle the level through one more flop
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign pin_s = chain[STAGES-1];

endmodule

// File: rtl/serbus_lock_ctl.sv
// Module: serbus_lock_ctl
// What it does: it counts rising edges of the synchronized serial clock while
//               chip-select is low. When the count reaches LOCK_PULSES, it
//               sets a sticky SPI lock.
// Assumes: cs_s and sck_s are synchronized levels. The lock is cleared only
//          by rst_n. soft_rst and chip-select high clear the count while
//          the block is not locked. An edge seen while cs_s is high is not
//          counted.
module serbus_lock_ctl #(
    parameter int LOCK_PULSES = 4,
    localparam int CNT_W      = $clog2(LOCK_PULSES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             cs_s,
    input  logic             sck_s,
    output logic             locked,
    output logic [CNT_W-1:0] pulse_cnt
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LOCK_PULSES - 1);
    localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(LOCK_PULSES);

    logic sck_d;
    logic sck_rise;

    // Purpose: delayed clock level for rising-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    assign sck_rise = sck_s & ~sck_d;

    // Purpose: count edges while selected and set the sticky lock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_cnt <= '0;
            locked    <= 1'b0;
        end else if (!locked) begin
            if (soft_rst || cs_s) begin
                pulse_cnt <= '0;
            end else if (sck_rise && (pulse_cnt < MAX_CNT)) begin
                pulse_cnt <= pulse_cnt + 1'b1;
                if (pulse_cnt == LAST_CNT) locked <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/serbus_mode_out.sv
// Module: serbus_mode_out
// What it does: it decodes the synchronized chip-select level, the lock state
//               and the wire-mode bit into registered engine enables and pad
//               output enables.
// Assumes: rd_drive and cfg_wire come from the core clock domain. Both pads
//          are released whenever chip-select is high.
module serbus_mode_out
    import serbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s,
    input  logic locked,
    input  logic cfg_wire,
    input  logic rd_drive,
    output logic i2c_en,
    output logic spi_en,
    output logic sdi_oe,
    output logic sdo_oe
);

    bus_mode_e mode_nxt;
    spi_wire_e wire_sel;
    logic      selected;

    // Purpose: pick the bus owner and the SPI variant
    always_comb begin
        mode_nxt = (locked || !cs_s) ? BUS_SPI : BUS_I2C;
        wire_sel = spi_wire_e'(cfg_wire);
        selected = !cs_s;
    end

    // Purpose: register the enables so the pad controls are glitch free
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i2c_en <= 1'b0;
            spi_en <= 1'b0;
            sdi_oe <= 1'b0;
            sdo_oe <= 1'b0;
        end else begin
            i2c_en <= (mode_nxt == BUS_I2C);
            spi_en <= (mode_nxt == BUS_SPI);
            sdo_oe <= selected && rd_drive && (wire_sel == SPI_4WIRE);
            sdi_oe <= selected && rd_drive && (wire_sel == SPI_3WIRE);
        end
    end

endmodule

// File: rtl/serbus_mode_sel.sv
// Module: serbus_mode_sel (top)
// What it does: it chooses between the I2C and SPI slave engines from the
//               chip-select level. It locks into SPI after LOCK_PULSES clock
//               edges seen while selected, and drives the pad output enables
//               for 3-wire or 4-wire SPI.
// Assumes: chip_sel_n and sck_pin are raw pad levels that are not yet
//          synchronized. rst_n is the power-on reset. soft_rst is a
//          one-cycle pulse.
module serbus_mode_sel #(
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_PULSES = 4,
    localparam int CNT_W      = $clog2(LOCK_PULSES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic chip_sel_n,
    input  logic sck_pin,
    input  logic cfg_wire,
    input  logic rd_drive,
    output logic i2c_en,
    output logic spi_en,
    output logic spi_locked,
    output logic sdi_oe,
    output logic sdo_oe
);

    logic [1:0]       pins_s;
    logic             cs_s;
    logic             sck_s;
    logic [CNT_W-1:0] pulse_cnt;

    serbus_pin_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b10)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin_i({chip_sel_n, sck_pin}),
        .pin_s(pins_s)
    );

    assign cs_s  = pins_s[1];
    assign sck_s = pins_s[0];

    serbus_lock_ctl #(
        .LOCK_PULSES(LOCK_PULSES)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .cs_s     (cs_s),
        .sck_s    (sck_s),
        .locked   (spi_locked),
        .pulse_cnt(pulse_cnt)
    );

    serbus_mode_out u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_s    (cs_s),
        .locked  (spi_locked),
        .cfg_wire(cfg_wire),
        .rd_drive(rd_drive),
        .i2c_en  (i2c_en),
        .spi_en  (spi_en),
        .sdi_oe  (sdi_oe),
        .sdo_oe  (sdo_oe)
    );

endmodule

// File: rtl/serbus_mode_chk.sv
// Module: serbus_mode_chk
// What it does: it holds the protocol properties of serbus_mode_sel and is
//               attached to it by a bind statement.
// Assumes: pulse_cnt is the internal edge counter of the top module.
module serbus_mode_chk #(
    parameter int LOCK_PULSES = 4,
    localparam int CNT_W      = $clog2(LOCK_PULSES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             i2c_en,
    input logic             spi_en,
    input logic             spi_locked,
    input logic             sdi_oe,
    input logic             sdo_oe,
    input logic [CNT_W-1:0] pulse_cnt
);

    p_excl_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(i2c_en && spi_en));

    p_cnt_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_cnt <= CNT_W'(LOCK_PULSES));

    p_lock_after_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_locked) |-> ($past(pulse_cnt) == CNT_W'(LOCK_PULSES - 1)));

    p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_locked |=> spi_locked);

    p_no_i2c_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_locked |=> (!i2c_en && spi_en));

    p_oe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdi_oe && sdo_oe));

    p_oe_off_i2c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        i2c_en |-> (!sdi_oe && !sdo_oe));

endmodule

bind serbus_mode_sel serbus_mode_chk #(
    .LOCK_PULSES(LOCK_PULSES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .i2c_en    (i2c_en),
    .spi_en    (spi_en),
    .spi_locked(spi_locked),
    .sdi_oe    (sdi_oe),
    .sdo_oe    (sdo_oe),
    .pulse_cnt (pulse_cnt)
);

// File: tb/serbus_mode_sel_bench.sv
// Bench: directed scenarios for serbus_mode_sel, one task per scenario.
module serbus_mode_sel_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0;
    logic chip_sel_n = 1'b1;
    logic sck_pin = 1'b0;
    logic cfg_wire = 1'b0;
    logic rd_drive = 1'b0;
    logic i2c_en, spi_en, spi_locked, sdi_oe, sdo_oe;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serbus_mode_sel u_serbus_mode_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .chip_sel_n(chip_sel_n),
        .sck_pin   (sck_pin),
        .cfg_wire  (cfg_wire),
        .rd_drive  (rd_drive),
        .i2c_en    (i2c_en),
        .spi_en    (spi_en),
        .spi_locked(spi_locked),
        .sdi_oe    (sdi_oe),
        .sdo_oe    (sdo_oe)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic sck_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            sck_pin = 1'b1; wait_clk(4);
            sck_pin = 1'b0; wait_clk(4);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; chip_sel_n = 1'b1; sck_pin = 1'b0; soft_rst = 1'b0;
        rd_drive = 1'b0; cfg_wire = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
    endtask

    // R10 / R1: reset state, then I2C mode with chip-select high
    task automatic t_reset();
        do_reset();
        wait_clk(1);
        chk("R10", "lock after reset", spi_locked, 1'b0);
        chk("R10", "sdo_oe after reset", sdo_oe, 1'b0);
        chk("R10", "sdi_oe after reset", sdi_oe, 1'b0);
        wait_clk(SETTLE);
        chk("R1", "i2c_en cs high", i2c_en, 1'b1);
        chk("R1", "spi_en cs high", spi_en, 1'b0);
        rd_drive = 1'b1; wait_clk(SETTLE);
        chk("R9", "sdo_oe cs high", sdo_oe, 1'b0);
        chk("R9", "sdi_oe cs high", sdi_oe, 1'b0);
        rd_drive = 1'b0;
    endtask

    // R2 / R7 / R8: SPI selection and pad enables in both variants
    task automatic t_spi_pads();
        do_reset();
        chip_sel_n = 1'b0; wait_clk(SETTLE);
        chk("R2", "spi_en cs low", spi_en, 1'b1);
        chk("R2", "i2c_en cs low", i2c_en, 1'b0);
        rd_drive = 1'b1; wait_clk(2);
        chk("R7", "sdo_oe 4-wire", sdo_oe, 1'b1);
        chk("R7", "sdi_oe 4-wire", sdi_oe, 1'b0);
        rd_drive = 1'b0; wait_clk(2);
        chk("R7", "sdo_oe 4-wire idle", sdo_oe, 1'b0);
        cfg_wire = 1'b1; rd_drive = 1'b1; wait_clk(2);
        chk("R8", "sdi_oe 3-wire", sdi_oe, 1'b1);
        chk("R8", "sdo_oe 3-wire", sdo_oe, 1'b0);
        chip_sel_n = 1'b1; wait_clk(SETTLE);
        chk("R9", "sdi_oe deselected", sdi_oe, 1'b0);
        chk("R5", "no lock without edges", spi_locked, 1'b0);
        rd_drive = 1'b0; cfg_wire = 1'b0;
    endtask

    // R3: three edges do not lock, the fourth does
    task automatic t_lock_count();
        do_reset();
        chip_sel_n = 1'b0; wait_clk(SETTLE);
        sck_pulses(3); wait_clk(2);
        chk("R3", "lock after 3 edges", spi_locked, 1'b0);
        sck_pulses(1); wait_clk(2);
        chk("R3", "lock after 4 edges", spi_locked, 1'b1);
        sck_pulses(3); wait_clk(2);
        chk("R3", "lock after extra edges", spi_locked, 1'b1);
    endtask

    // R4: lock holds with chip-select high; only rst_n clears it
    task automatic t_lock_sticky();
        chip_sel_n = 1'b1; wait_clk(SETTLE);
        chk("R4", "i2c_en locked cs high", i2c_en, 1'b0);
        chk("R4", "spi_en locked cs high", spi_en, 1'b1);
        chk("R4", "lock cs high", spi_locked, 1'b1);
        rd_drive = 1'b1; wait_clk(2);
        chk("R9", "sdo_oe locked deselected", sdo_oe, 1'b0);
        rd_drive = 1'b0;
        do_reset(); wait_clk(SETTLE);
        chk("R4", "lock cleared by rst_n", spi_locked, 1'b0);
        chk("R4", "i2c_en after rst_n", i2c_en, 1'b1);
    endtask

    // R5: chip-select high clears the count
    task automatic t_cs_clears();
        do_reset();
        chip_sel_n = 1'b0; wait_clk(SETTLE);
        sck_pulses(3);
        chip_sel_n = 1'b1; wait_clk(SETTLE);
        chip_sel_n = 1'b0; wait_clk(SETTLE);
        sck_pulses(1); wait_clk(2);
        chk("R5", "count cleared by cs high", spi_locked, 1'b0);
        sck_pulses(3); wait_clk(2);
        chk("R5", "lock after fresh four", spi_locked, 1'b1);
    endtask

    // R5: fourth edge and chip-select release sampled in the same cycle
    task automatic t_coincide();
        do_reset();
        chip_sel_n = 1'b0; wait_clk(SETTLE);
        sck_pulses(3);
        sck_pin = 1'b1; chip_sel_n = 1'b1;
        wait_clk(SETTLE);
        sck_pin = 1'b0; wait_clk(SETTLE);
        chk("R5", "edge with cs release not counted", spi_locked, 1'b0);
        chk("R5", "i2c_en after coincident release", i2c_en, 1'b1);
    endtask

    // R6: soft reset clears the count but never the lock
    task automatic t_soft_reset();
        do_reset();
        chip_sel_n = 1'b0; wait_clk(SETTLE);
        sck_pulses(2);
        soft_rst = 1'b1; wait_clk(1); soft_rst = 1'b0;
        sck_pulses(2); wait_clk(2);
        chk("R6", "count cleared by soft reset", spi_locked, 1'b0);
        sck_pulses(2); wait_clk(2);
        chk("R6", "lock after four post-reset edges", spi_locked, 1'b1);
        soft_rst = 1'b1; wait_clk(1); soft_rst = 1'b0;
        chip_sel_n = 1'b1; wait_clk(SETTLE);
        chk("R6", "lock survives soft reset", spi_locked, 1'b1);
        chk("R6", "i2c_en stays off", i2c_en, 1'b0);
    endtask

    initial begin
        t_reset();
        t_spi_pads();
        t_lock_count();
        t_lock_sticky();
        t_cs_clears();
        t_coincide();
        t_soft_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    n_run++; n_fail++;
                    $display("FAIL watchdog: actual=hung expected=finished");
                end
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule